// File: doc/BRIEF.md
# Serial-Key Unlock Controller for a Hidden Clock Register File

This block sits between a host's memory strobes and an SRAM. It hides a 64-bit clock register file behind ordinary memory traffic. While locked, every host access is passed to the SRAM, and the block watches one data line (`dq0_in`) on each write. When 64 writes in a row carry the expected key, LSB first, the block opens a transfer window. The next 64 host accesses go to the clock registers, one bit per access, and the SRAM chip enable is held inactive for the whole window.

In the window, a read shifts out one bit of a copy of the timekeeper image. That copy is taken at the moment of unlock. A write shifts one bit into a staging buffer. The buffer is loaded into the timekeeper in a single pulse, and only when all 64 cycles of the window were writes.

A mismatched key bit stops the matching until the next read, and any read starts the key over from bit 0. A low on the external reset pin abandons a match or a window in progress, but only while the reset-enable bit of the timekeeper image is 0.

The strobes are sampled on `clk`. Each strobe must stay active, and then inactive, for at least two clock periods.

Top module: `phx_unlock_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ram_ce_n` is 1, `dq0_oe` is 0 and `tk_load` is 0.
- R2: Outside a transfer window, `ram_ce_n` equals `ce_n` delayed by one clock. A read is `ce_n`=0, `oe_n`=0, `we_n`=1; a write is `ce_n`=0, `we_n`=0.
- R3: The n-th write since the last read (n = 0..63) is compared with bit n of parameter KEY on `dq0_in`. After 64 matches, the following accesses form a transfer window.
- R4: After a mismatched write, later writes never open a window until a read occurs.
- R5: A read outside a window resets key matching to bit 0, so a full key sent after the read unlocks.
- R6: During a window access, `ram_ce_n` stays 1. On the k-th access (k = 0..63), if it is a read, `dq0_out` shows bit k of the image and `dq0_oe` is 1.
- R7: Window reads return the `tk_time_i` value present at the unlock write, even if `tk_time_i` changes later.
- R8: A window of 64 writes gives exactly one one-cycle `tk_load` pulse. `tk_data` bit k is the value written on the k-th window access.
- R9: A window that contains any read, or that is aborted, produces no `tk_load`.
- R10: After the 64th window access, the block returns to key matching and the next access reaches the SRAM.
- R11: When `tk_time_i[RSTEN_BIT]` (default 36) is 0, a low `rst_pin_n` aborts matching or a window and resets the pointer. When that bit is 1, `rst_pin_n` has no effect.
- R12: Strobe activity while `ce_n` is 1 does not count as an access: it does not move the key pointer, and it does not raise `dq0_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| dq0_in | input | 1 | Host data bit 0 on writes |
| rst_pin_n | input | 1 | External abort input, active low |
| tk_time_i | input | BITS | Current timekeeper register image |
| ram_ce_n | output | 1 | Chip enable to the SRAM, active low |
| dq0_out | output | 1 | Clock data bit driven on window reads |
| dq0_oe | output | 1 | High while `dq0_out` should drive the bus |
| tk_load | output | 1 | One-cycle pulse that loads `tk_data` into the timekeeper |
| tk_data | output | BITS | Image written through the window |

## Verification
Directed patterns separate the cases a single-path design would confuse:
- A clean key tests the basic unlock.
- A key with one flipped bit, followed by the remaining correct bits, checks the lockout.
- A partial key, then a read, then a full key, checks the pointer reset.
- Strobes with chip enable inactive, placed in the middle of the key, check that non-accesses are ignored.

Windows made of all reads, all writes, mixed accesses, and windows aborted by the reset pin check separately the snapshot path, the all-or-nothing commit, and the abort gate for both settings of the enable bit. Random passes vary the key-corruption point, the window mix and the timekeeper image. Each access is compared against a bench model of the pointer state.

// File: rtl/phx_pkg.sv
package phx_pkg;
  typedef enum logic [1:0] {
    PH_SEEK   = 2'd0,
    PH_LOCKED = 2'd1,
    PH_XFER   = 2'd2
  } phase_t;

  localparam logic [63:0] PHX_KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;
endpackage

// File: rtl/phx_strobe.sv
module phx_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic act_o,
  output logic evt_o,
  output logic evt_wr_o
);
  logic act_q;

  // an access exists only while chip enable and one strobe are low
  assign act_o    = ~ce_n & (~oe_n | ~we_n);
  assign evt_o    = act_o & ~act_q;
  assign evt_wr_o = ~we_n;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act_o;
  end
endmodule

// File: rtl/phx_seq.sv
module phx_seq
  import phx_pkg::*;
#(
  parameter int          BITS = 64,
  parameter logic [BITS-1:0] KEY = PHX_KEY_DEFAULT[BITS-1:0],
  localparam int         PW   = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic          evt_wr,
  input  logic          din,
  input  logic          abort,
  output phase_t        phase_o,
  output logic [PW-1:0] ptr_o,
  output logic          unlock_o,
  output logic          xfer_hit_o,
  output logic          last_o
);
  phase_t        ph_q, ph_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          last;
  logic          key_ok;

  assign last   = (ptr_q == PW'(BITS - 1));
  assign key_ok = (din == KEY[ptr_q]);

  always_comb begin
    ph_d  = ph_q;
    ptr_d = ptr_q;
    if (abort) begin
      ph_d  = PH_SEEK;
      ptr_d = '0;
    end else if (evt) begin
      unique case (ph_q)
        PH_SEEK: begin
          if (!evt_wr) begin
            ptr_d = '0;
          end else if (key_ok) begin
            if (last) begin
              ph_d  = PH_XFER;
              ptr_d = '0;
            end else begin
              ptr_d = ptr_q + 1'b1;
            end
          end else begin
            ph_d = PH_LOCKED;
          end
        end
        PH_LOCKED: begin
          if (!evt_wr) begin
            ph_d  = PH_SEEK;
            ptr_d = '0;
          end
        end
        PH_XFER: begin
          if (last) begin
            ph_d  = PH_SEEK;
            ptr_d = '0;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_SEEK;
          ptr_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_SEEK;
      ptr_q <= '0;
    end else begin
      ph_q  <= ph_d;
      ptr_q <= ptr_d;
    end
  end

  assign phase_o    = ph_q;
  assign ptr_o      = ptr_q;
  assign last_o     = last;
  assign unlock_o   = evt & ~abort & (ph_q == PH_SEEK) & evt_wr & key_ok & last;
  assign xfer_hit_o = evt & ~abort & (ph_q == PH_XFER);
endmodule

// File: rtl/phx_xfer.sv
module phx_xfer #(
  parameter  int BITS = 64,
  localparam int PW   = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            unlock,
  input  logic            xfer_hit,
  input  logic            evt_wr,
  input  logic            last,
  input  logic            din,
  input  logic [PW-1:0]   ptr,
  input  logic [BITS-1:0] tk_time,
  output logic            dq_o,
  output logic            load_o,
  output logic [BITS-1:0] data_o
);
  logic [BITS-1:0] snap_q;
  logic [BITS-1:0] wbuf_q;
  logic [BITS-1:0] merged;
  logic            all_wr_q;
  logic            dq_q;
  logic            load_q;
  logic [BITS-1:0] data_q;

  always_comb begin
    merged      = wbuf_q;
    merged[ptr] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q   <= '0;
      wbuf_q   <= '0;
      all_wr_q <= 1'b0;
      dq_q     <= 1'b0;
      load_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      load_q <= 1'b0;
      if (unlock) begin
        snap_q   <= tk_time;
        all_wr_q <= 1'b1;
      end
      if (xfer_hit) begin
        if (evt_wr) begin
          wbuf_q <= merged;
          if (last && all_wr_q) begin
            load_q <= 1'b1;
            data_q <= merged;
          end
        end else begin
          dq_q     <= snap_q[ptr];
          all_wr_q <= 1'b0;
        end
      end
    end
  end

  assign dq_o   = dq_q;
  assign load_o = load_q;
  assign data_o = data_q;
endmodule

// File: rtl/phx_unlock_ctrl.sv
module phx_unlock_ctrl
  import phx_pkg::*;
#(
  parameter int              BITS      = 64,
  parameter logic [BITS-1:0] KEY       = PHX_KEY_DEFAULT[BITS-1:0],
  parameter int              RSTEN_BIT = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic            dq0_in,
  input  logic            rst_pin_n,
  input  logic [BITS-1:0] tk_time_i,
  output logic            ram_ce_n,
  output logic            dq0_out,
  output logic            dq0_oe,
  output logic            tk_load,
  output logic [BITS-1:0] tk_data
);
  localparam int PW = $clog2(BITS);

  logic          act, evt, evt_wr;
  logic          abort;
  phase_t        phase;
  logic [PW-1:0] ptr;
  logic          unlock, xfer_hit, last;
  logic          blk_q, blk_d;
  logic          ram_ce_q, oe_q;

  assign abort = ~rst_pin_n & ~tk_time_i[RSTEN_BIT];

  phx_strobe u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .act_o(act), .evt_o(evt), .evt_wr_o(evt_wr)
  );

  phx_seq #(.BITS(BITS), .KEY(KEY)) u_seq (
    .clk(clk), .rst(rst), .evt(evt), .evt_wr(evt_wr), .din(dq0_in),
    .abort(abort), .phase_o(phase), .ptr_o(ptr), .unlock_o(unlock),
    .xfer_hit_o(xfer_hit), .last_o(last)
  );

  phx_xfer #(.BITS(BITS)) u_xfer (
    .clk(clk), .rst(rst), .unlock(unlock), .xfer_hit(xfer_hit),
    .evt_wr(evt_wr), .last(last), .din(dq0_in), .ptr(ptr),
    .tk_time(tk_time_i), .dq_o(dq0_out), .load_o(tk_load), .data_o(tk_data)
  );

  // the blocking decision is made at the access start and held until it ends
  assign blk_d = act & (evt ? xfer_hit : blk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q    <= 1'b0;
      ram_ce_q <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      blk_q    <= blk_d;
      ram_ce_q <= ce_n | blk_d;
      oe_q     <= act & (evt ? (xfer_hit & ~evt_wr) : oe_q);
    end
  end

  assign ram_ce_n = ram_ce_q;
  assign dq0_oe   = oe_q;
endmodule

// File: rtl/phx_unlock_chk.sv
module phx_unlock_chk #(
  parameter int BITS      = 64,
  parameter int RSTEN_BIT = 36
) (
  input logic            clk,
  input logic            rst,
  input logic            ce_n,
  input logic            rst_pin_n,
  input logic [BITS-1:0] tk_time_i,
  input logic            ram_ce_n,
  input logic            dq0_oe,
  input logic            tk_load
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ram_ce_n && !dq0_oe && !tk_load));

  // R2
  ce_idle_passes_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> ram_ce_n);

  // R6
  drive_blocks_ram_chk: assert property (@(posedge clk) disable iff (rst)
    dq0_oe |-> ram_ce_n);

  // R8
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tk_load |=> !tk_load);

  // R11
  abort_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_pin_n && !tk_time_i[RSTEN_BIT]) |=> !tk_load);

  // R12
  ce_idle_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dq0_oe);
endmodule

bind phx_unlock_ctrl phx_unlock_chk #(.BITS(BITS), .RSTEN_BIT(RSTEN_BIT)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .rst_pin_n(rst_pin_n),
  .tk_time_i(tk_time_i), .ram_ce_n(ram_ce_n), .dq0_oe(dq0_oe), .tk_load(tk_load)
);

// File: tb/sim_phx_unlock_ctrl.sv
module sim_phx_unlock_ctrl;
  localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam int RB = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq0_in = 1'b0, rst_pin_n = 1'b1;
  logic [63:0] tk_time = 64'hFFFF_FFFF_FFFF_FFFF;
  logic ram_ce_n, dq0_out, dq0_oe, tk_load;
  logic [63:0] tk_data;

  always #10 clk = ~clk;

  phx_unlock_ctrl #(.BITS(64), .KEY(KEY), .RSTEN_BIT(RB)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq0_in(dq0_in), .rst_pin_n(rst_pin_n), .tk_time_i(tk_time),
    .ram_ce_n(ram_ce_n), .dq0_out(dq0_out), .dq0_oe(dq0_oe),
    .tk_load(tk_load), .tk_data(tk_data)
  );

  int ncmp = 0, nfail = 0;
  int nload = 0, exp_nload = 0;
  bit done = 0;
  string cur_req = "R2";
  string dq_req = "R6";

  // model: 0 seeking, 1 locked out, 2 window
  int mst = 0, mptr = 0;
  bit mall = 0;
  logic [63:0] msnap = '0, mwbuf = '0, exp_ld = '0;

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    ncmp++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && tk_load) begin
      nload++;
      chk("R8 load data", tk_data, exp_ld);
      if (nload > exp_nload) chk("R9 unexpected load", 64'(nload), 64'(exp_nload));
    end
  end

  task automatic acc(input bit rd, input bit b);
    bit eb, ed;
    eb = 0; ed = 0;
    if (mst == 2) begin
      eb = 1;
      if (rd) begin ed = msnap[mptr]; mall = 0; end
      else mwbuf[mptr] = b;
      if (mptr == 63) begin
        if (!rd && mall) begin exp_ld = mwbuf; exp_nload++; end
        mst = 0; mptr = 0;
      end else mptr++;
    end else if (rd) begin
      mst = 0; mptr = 0;
    end else if (mst == 0) begin
      if (b == KEY[mptr]) begin
        if (mptr == 63) begin mst = 2; mptr = 0; msnap = tk_time; mall = 1; end
        else mptr++;
      end else mst = 1;
    end
    @(negedge clk);
    ce_n = 0; oe_n = !rd; we_n = rd; dq0_in = b;
    @(negedge clk); @(negedge clk);
    chk(cur_req, ram_ce_n, eb);
    if (eb && rd) begin
      chk(dq_req, dq0_out, ed);
      chk("R6 oe", dq0_oe, 1);
    end else chk("R2 oe", dq0_oe, 0);
    ce_n = 1; oe_n = 1; we_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R2 idle", ram_ce_n, 1);
  endtask

  task automatic ghost(input bit rd);
    @(negedge clk);
    ce_n = 1; oe_n = !rd; we_n = rd; dq0_in = ~dq0_in;
    @(negedge clk); @(negedge clk);
    chk("R12 ghost ce", ram_ce_n, 1);
    chk("R12 ghost oe", dq0_oe, 0);
    oe_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic pin_pulse();
    if (tk_time[RB] == 1'b0) begin mst = 0; mptr = 0; end
    @(negedge clk); rst_pin_n = 0;
    @(negedge clk); rst_pin_n = 1;
  endtask

  task automatic send_key(input int from, input int upto, input int bad);
    for (int i = from; i < upto; i++) acc(1'b0, KEY[i] ^ (i == bad));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce", ram_ce_n, 1); chk("R1 oe", dq0_oe, 0); chk("R1 ld", tk_load, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 ce after", ram_ce_n, 1); chk("R1 ld after", tk_load, 0);

    // R3 R12: key with ghost strobes in the middle, then snapshot reads (R7)
    cur_req = "R12";
    tk_time = 64'hA5F0_1234_DEAD_BEEF | (64'd1 << RB);
    acc(1, 0);
    send_key(0, 32, -1);
    ghost(1); ghost(0);
    cur_req = "R3";
    send_key(32, 64, -1);
    tk_time = 64'h0123_4567_89AB_CDEF | (64'd1 << RB);
    cur_req = "R6"; dq_req = "R7";
    for (int k = 0; k < 64; k++) acc(1, 0);
    dq_req = "R6";
    cur_req = "R10";
    acc(0, 1);

    // R8: full write window
    cur_req = "R8";
    acc(1, 0); send_key(0, 64, -1);
    for (int k = 0; k < 64; k++) acc(0, ((k * 7) % 5) == 1);
    chk("R8 load count", 64'(nload), 64'(exp_nload));

    // R9: mixed window gives no load
    cur_req = "R9";
    acc(1, 0); send_key(0, 64, -1);
    for (int k = 0; k < 64; k++) acc(k == 40, 1);
    chk("R9 no load", 64'(nload), 64'(exp_nload));

    // R4: mismatch then the rest of the key
    cur_req = "R4";
    acc(1, 0); send_key(0, 64, 10);
    acc(0, 1); acc(0, 0);
    // R5: partial key, read, full key
    cur_req = "R5";
    acc(1, 0); send_key(0, 30, -1); acc(1, 0); send_key(0, 64, -1);
    acc(1, 0);
    for (int k = 1; k < 64; k++) acc(1, 0);

    // R11: abort enabled (bit clear) mid window and mid key
    cur_req = "R11";
    tk_time = 64'h0F0F_0F0F_0F0F_0F0F & ~(64'd1 << RB);
    acc(1, 0); send_key(0, 64, -1);
    for (int k = 0; k < 20; k++) acc(0, 1);
    pin_pulse();
    acc(0, 0);
    acc(1, 0); send_key(0, 40, -1); pin_pulse(); send_key(40, 64, -1);
    acc(1, 0);
    chk("R11 abort no load", 64'(nload), 64'(exp_nload));
    // R11: abort disabled (bit set), pulse ignored
    tk_time = tk_time | (64'd1 << RB);
    acc(1, 0); send_key(0, 40, -1); pin_pulse(); send_key(40, 64, -1);
    for (int k = 0; k < 64; k++) acc(0, k[0]);
    chk("R11 ignored load", 64'(nload), 64'(exp_nload));

    // random passes
    cur_req = "R3";
    for (int it = 0; it < 30; it++) begin
      int bad, mode;
      tk_time = {$urandom, $urandom};
      tk_time[RB] = ($urandom % 4) != 0;
      bad = (($urandom % 4) == 0) ? int'($urandom % 64) : -1;
      mode = $urandom % 3;
      acc(1, 0);
      send_key(0, 64, bad);
      if ($urandom % 5 == 0) pin_pulse();
      for (int k = 0; k < 64; k++)
        acc(mode == 2 ? 1'b1 : (mode == 1 ? (($urandom % 8) == 0) : 1'b0), $urandom % 2);
    end
    repeat (4) @(negedge clk);
    chk("R8 final load count", 64'(nload), 64'(exp_nload));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule